// File: doc/BRIEF.md
# Converter Clock Prescaler Selector

This block produces the clock for a sampling converter. It has two ways of making that clock. In the asynchronous mode it picks one of three kernel clocks: the system clock or one of two auxiliary PLL outputs. It then divides that clock by a ratio taken from a fixed set that mixes powers of two with the even ratios 6, 10 and 12. The result has no fixed phase relation to the bus clock.

In the synchronous modes the block divides the bus clock by 1, 2 or 4 instead. Dividing the bus clock by 1 is only legal when the bus prescaler itself divides by 1. When that combination is selected with any other bus prescaler, the block raises an error flag.

The integration has to keep the output clock at or below 80 MHz. It does this through its choice of source and ratio; the block does not check the frequency. Software changes the mode, the source, the ratio code and the bus prescaler setting at run time. A new ratio is applied only at the end of the current output period, so the converter never sees a shortened pulse.

Top module: `conv_clk_presc`

## Requirements
- R1: The kernel source select picks the source clock for the asynchronous path: code 0 selects the system clock, code 1 selects auxiliary clock A, and codes 2 and 3 select auxiliary clock B.
- R2: In the asynchronous mode, the 4-bit prescaler codes 0 to 11 divide the selected kernel clock by 1, 2, 4, 6, 8, 10, 12, 16, 32, 64, 128 and 256, in that order.
- R3: Prescaler codes 12 to 15 divide by 256.
- R4: For every even ratio N the output stays high for N/2 source periods and low for N/2 source periods. With ratio 1 the source clock is passed through unchanged.
- R5: A change of the prescaler code takes effect only when the current output period ends. The period that is already running completes at the old length, and the next period uses the new length.
- R6: The 2-bit mode field selects the output clock as follows: code 0 gives the asynchronous path; codes 1, 2 and 3 give the bus clock divided by 1, 2 and 4, each with 50% duty.
- R7: The bus prescaler setting is a 4-bit code, and codes 0 to 7 mean divide-by-1. When the mode is 1 and the bus prescaler code is 8 or above, the error flag is high one bus clock later.
- R8: In modes 0, 2 and 3 the error flag is low one bus clock later, whatever the bus prescaler code is.
- R9: While reset is asserted the error flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus clock; source of the synchronous modes |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_sys | input | 1 | System clock, kernel source 0 |
| clk_aux_a | input | 1 | Auxiliary PLL output, kernel source 1 |
| clk_aux_b | input | 1 | Auxiliary PLL output, kernel sources 2 and 3 |
| src_sel | input | 2 | Kernel source select |
| mode_sel | input | 2 | Output mode: asynchronous, or bus clock divided by 1, 2 or 4 |
| presc_code | input | 4 | Asynchronous divide-ratio code |
| bus_presc_code | input | 4 | Bus prescaler setting; codes below 8 mean divide-by-1 |
| conv_clk | output | 1 | Converter clock |
| cfg_err | output | 1 | Illegal synchronous divide-by-1 combination |

## Verification
The bench sweeps all sixteen prescaler codes. For each code it measures the period and the high time of the output in real time. A design with a wrong table entry, a clamp that does not cover codes 12 to 15, or an off-by-one terminal count gives a wrong period. A design that toggles at the wrong count gives a wrong high time.

The bench also switches from ratio 256 to ratio 2 in the middle of a period. A design that applies the new ratio at once cuts that period short and produces a runt pulse.

The bus prescaler codes are swept in every mode, so an error flag that is tied to the wrong bit or to the wrong mode gets reported. Each kernel source and each synchronous ratio is measured against its own period, so a design that routes the wrong clock shows up as a wrong period.

// File: rtl/conv_clk_pkg.sv
package conv_clk_pkg;

    typedef enum logic [1:0] {
        MODE_ASYNC = 2'd0,
        MODE_SYNC1 = 2'd1,
        MODE_SYNC2 = 2'd2,
        MODE_SYNC4 = 2'd3
    } conv_mode_e;

    // Prescaler code to divide ratio; out-of-range codes clamp to the largest ratio.
    function automatic logic [8:0] code_to_ratio(input logic [3:0] code);
        logic [8:0] r;
        case (code)
            4'd0:    r = 9'd1;
            4'd1:    r = 9'd2;
            4'd2:    r = 9'd4;
            4'd3:    r = 9'd6;
            4'd4:    r = 9'd8;
            4'd5:    r = 9'd10;
            4'd6:    r = 9'd12;
            4'd7:    r = 9'd16;
            4'd8:    r = 9'd32;
            4'd9:    r = 9'd64;
            4'd10:   r = 9'd128;
            default: r = 9'd256;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cc_src_mux.sv
module cc_src_mux (
    input  logic       clk_sys,
    input  logic       clk_aux_a,
    input  logic       clk_aux_b,
    input  logic [1:0] sel_i,
    output logic       kclk_o
);
    always_comb begin
        case (sel_i)
            2'd0:    kclk_o = clk_sys;
            2'd1:    kclk_o = clk_aux_a;
            default: kclk_o = clk_aux_b;
        endcase
    end
endmodule

// File: rtl/cc_div.sv
module cc_div #(
    parameter int CNT_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [CNT_W:0] ratio_i,
    output logic           div_clk_o
);
    localparam int RAT_W = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [RAT_W-1:0] ratio;
        logic             ph;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    term;

    always_comb begin
        st_d = st_q;
        term = ({1'b0, st_q.cnt} == (st_q.ratio - RAT_W'(1)));
        if (term) begin
            st_d.cnt   = '0;
            st_d.ratio = ratio_i;
        end else begin
            st_d.cnt   = st_q.cnt + CNT_W'(1);
        end
        st_d.ph = ({1'b0, st_d.cnt} < (st_d.ratio >> 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.ratio <= RAT_W'(1);
            st_q.ph    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_clk_o = (st_q.ratio == RAT_W'(1)) ? clk : st_q.ph;

    // R5: ratio only reloads at the end of a period
    a_r5_reload_at_terminal: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ratio != $past(st_q.ratio)) |-> ({1'b0, $past(st_q.cnt)} == $past(st_q.ratio) - RAT_W'(1)));

    // R2: counter stays inside the active period
    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, st_q.cnt} < st_q.ratio));

    // R4: high phase starts at count zero
    a_r4_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ph) |-> (st_q.cnt == '0));

    // R4: high phase ends at half the period
    a_r4_fall_at_half: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.ph) |-> ({1'b0, st_q.cnt} == (st_q.ratio >> 1)));
endmodule

// File: rtl/cc_err.sv
module cc_err #(
    parameter int BUS_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  conv_clk_pkg::conv_mode_e mode_i,
    input  logic [BUS_W-1:0]        bus_presc_i,
    output logic                    err_o
);
    import conv_clk_pkg::*;

    localparam logic [BUS_W-1:0] FIRST_DIV = BUS_W'(1) << (BUS_W - 1);

    typedef struct packed {
        logic err;
    } err_st_t;

    err_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = (mode_i == MODE_SYNC1) && (bus_presc_i >= FIRST_DIV);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_o = st_q.err;

    // R7: illegal divide-by-1 raises the flag next cycle
    a_r7_flag_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_SYNC1 && bus_presc_i >= FIRST_DIV) |=> err_o);

    // R8: other modes never flag
    a_r8_quiet_other_modes: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MODE_SYNC1) |=> !err_o);

    // R9: flag low while in reset
    always_comb begin
        if (!rst_n) a_r9_reset_low: assert (!err_o);
    end
endmodule

// File: rtl/conv_clk_presc.sv
module conv_clk_presc #(
    parameter int CNT_W  = 8,
    parameter int CODE_W = 4,
    parameter int BUS_W  = 4
) (
    input  logic              clk_bus,
    input  logic              rst_n,
    input  logic              clk_sys,
    input  logic              clk_aux_a,
    input  logic              clk_aux_b,
    input  logic [1:0]        src_sel,
    input  logic [1:0]        mode_sel,
    input  logic [CODE_W-1:0] presc_code,
    input  logic [BUS_W-1:0]  bus_presc_code,
    output logic              conv_clk,
    output logic              cfg_err
);
    import conv_clk_pkg::*;

    localparam int RAT_W = CNT_W + 1;

    conv_mode_e       mode;
    logic             kclk;
    logic             async_clk;
    logic             sync_clk;
    logic [RAT_W-1:0] async_ratio;
    logic [RAT_W-1:0] sync_ratio;

    assign mode = conv_mode_e'(mode_sel);

    always_comb begin
        async_ratio = RAT_W'(code_to_ratio(4'(presc_code)));
        case (mode)
            MODE_SYNC2: sync_ratio = RAT_W'(2);
            MODE_SYNC4: sync_ratio = RAT_W'(4);
            default:    sync_ratio = RAT_W'(1);
        endcase
    end

    cc_src_mux u_src (
        .clk_sys  (clk_sys),
        .clk_aux_a(clk_aux_a),
        .clk_aux_b(clk_aux_b),
        .sel_i    (src_sel),
        .kclk_o   (kclk)
    );

    cc_div #(.CNT_W(CNT_W)) u_async_div (
        .clk      (kclk),
        .rst_n    (rst_n),
        .ratio_i  (async_ratio),
        .div_clk_o(async_clk)
    );

    cc_div #(.CNT_W(CNT_W)) u_sync_div (
        .clk      (clk_bus),
        .rst_n    (rst_n),
        .ratio_i  (sync_ratio),
        .div_clk_o(sync_clk)
    );

    cc_err #(.BUS_W(BUS_W)) u_err (
        .clk        (clk_bus),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .bus_presc_i(bus_presc_code),
        .err_o      (cfg_err)
    );

    assign conv_clk = (mode == MODE_ASYNC) ? async_clk : sync_clk;
endmodule

// File: tb/tb_conv_clk_presc.sv
`timescale 1ns/1ps
module tb_conv_clk_presc;
    logic       clk_bus = 0, clk_sys = 0, clk_aux_a = 0, clk_aux_b = 0;
    logic       rst_n = 0;
    logic [1:0] src_sel = 0, mode_sel = 0;
    logic [3:0] presc_code = 0, bus_presc_code = 0;
    logic       conv_clk, cfg_err;
    int         n_chk = 0, n_fail = 0;

    always #4 clk_bus   = ~clk_bus;
    always #5 clk_sys   = ~clk_sys;
    always #7 clk_aux_a = ~clk_aux_a;
    always #3 clk_aux_b = ~clk_aux_b;

    conv_clk_presc dut (
        .clk_bus(clk_bus), .rst_n(rst_n), .clk_sys(clk_sys),
        .clk_aux_a(clk_aux_a), .clk_aux_b(clk_aux_b), .src_sel(src_sel),
        .mode_sel(mode_sel), .presc_code(presc_code),
        .bus_presc_code(bus_presc_code), .conv_clk(conv_clk), .cfg_err(cfg_err)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int ratio_of(input int code);
        int tbl[12] = '{1, 2, 4, 6, 8, 10, 12, 16, 32, 64, 128, 256};
        return (code < 12) ? tbl[code] : 256;
    endfunction

    // Measures one settled period and its high time in ns.
    task automatic measure(input string tag, input int period, input string dtag);
        realtime t0, th, t1;
        repeat (3) @(posedge conv_clk);
        t0 = $realtime;
        @(negedge conv_clk);
        th = $realtime;
        @(posedge conv_clk);
        t1 = $realtime;
        chk(tag, longint'(t1 - t0), period);
        chk(dtag, longint'(th - t0), period / 2);
    endtask

    initial begin
        #1_000_000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        realtime t0, t1, t2;
        repeat (4) @(posedge clk_bus);
        @(negedge clk_bus);
        chk("R9 reset flag", cfg_err, 0);
        rst_n = 1;

        // R2, R3, R4: full code sweep on the system clock
        for (int c = 0; c < 16; c++) begin
            presc_code = 4'(c);
            measure(c < 12 ? "R2 period" : "R3 period", ratio_of(c) * 10, "R4 duty");
        end

        // R1: each kernel source
        src_sel = 2'd1; presc_code = 4'd3;
        measure("R1 aux A", 6 * 14, "R4 duty aux A");
        src_sel = 2'd2; presc_code = 4'd5;
        measure("R1 aux B", 10 * 6, "R4 duty aux B");
        src_sel = 2'd3;
        measure("R1 aux B code 3", 10 * 6, "R4 duty aux B code 3");

        // R5: ratio change mid-period completes old period first
        src_sel = 2'd0; presc_code = 4'd11;
        repeat (3) @(posedge conv_clk);
        t0 = $realtime;
        #20 presc_code = 4'd1;
        @(posedge conv_clk);
        t1 = $realtime;
        @(posedge conv_clk);
        t2 = $realtime;
        chk("R5 old period kept", longint'(t1 - t0), 2560);
        chk("R5 new period", longint'(t2 - t1), 20);

        // R6: synchronous modes
        mode_sel = 2'd1;
        measure("R6 bus div1", 8, "R6 duty div1");
        mode_sel = 2'd2;
        measure("R6 bus div2", 16, "R6 duty div2");
        mode_sel = 2'd3;
        measure("R6 bus div4", 32, "R6 duty div4");

        // R7, R8: error flag sweep
        for (int m = 0; m < 4; m++) begin
            for (int b = 0; b < 16; b++) begin
                mode_sel = 2'(m);
                bus_presc_code = 4'(b);
                repeat (2) @(posedge clk_bus);
                @(negedge clk_bus);
                if (m == 1) chk("R7 err flag", cfg_err, (b >= 8) ? 1 : 0);
                else        chk("R8 err quiet", cfg_err, 0);
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule